// File: doc/BRIEF.md
# Sectioned Register Address Sequencer

This block produces the byte address for accesses to a 64-byte control register space that holds five sections: two 8-byte alarm sections, one 1-byte control section, an 8-byte time section and a 1-byte status section. A host starts an operation by presenting the device select byte together with either an explicit start address or a request to continue from the stored pointer. Each completed byte transfer then advances the address by one. When the address reaches the last byte of its section, it wraps back to the first byte of that same section, so a burst never leaves the section where it began.

The single-byte status section allows exactly one byte per operation. A further byte in the same operation raises a one-cycle terminate pulse and closes the operation. The address register is also the current-address pointer. It keeps its value between operations, so a later operation can continue from the byte after the last one transferred. Start addresses at or above 0x40, and addresses in the gaps between sections, are refused and flagged. The register storage and the serial bus protocol sit outside this block.

Top module: `rsq_addr_seq`

## Requirements
- R1: After reset, `addr` is 0, `active` is 0, `sect` is 7 (none), and both `addr_bad` and `terminate` are 0.
- R2: A start with `start_valid` high and `start_dev[7:1]` equal to 7'b1101111 (bit 0 is the read/write bit and may take either value), at a valid address, makes `addr` equal to that address and `active` equal to 1 in the next cycle. `sect` then reads 0 for 0x00–0x07, 1 for 0x08–0x0F, 2 for 0x10, 3 for 0x30–0x37 and 4 for 0x3F.
- R3: A start whose select byte does not match changes neither `addr`, `active`, `sect` nor `addr_bad`.
- R4: While `active` is 1, each `byte_done` moves `addr` to the next byte of the current section in the next cycle, and `sect` does not change.
- R5: A `byte_done` at the last byte of a section loads the first byte of the same section: 0x07→0x00, 0x0F→0x08, 0x37→0x30. The control byte 0x10 steps to itself.
- R6: In the status section the first `byte_done` leaves `addr` at 0x3F. A second `byte_done` in the same operation raises `terminate` for exactly one cycle, clears `active` in that same cycle, and leaves `addr` unchanged.
- R7: A matched start at an address of 0x40 or above, or in a gap (0x11–0x2F, 0x38–0x3E), sets `addr_bad` to 1, clears `active`, sets `sect` to 7 and keeps `addr`. The next matched start reloads `addr_bad` from its own validity.
- R8: `addr` holds its value after an operation ends. A start with `start_from_ptr` set resumes from that value and ignores `start_addr`.
- R9: `byte_done` while `active` is 0 leaves `addr` unchanged.
- R10: `op_end` clears `active` in the next cycle and leaves `addr` unchanged.
- R11: A matched start in the same cycle as `byte_done` or `op_end` takes priority, and those other inputs are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Start of an operation this cycle |
| start_dev | input | 8 | Device select byte that comes with the start |
| start_from_ptr | input | 1 | Resume from the stored pointer and ignore start_addr |
| start_addr | input | 8 | Explicit start address |
| byte_done | input | 1 | One byte transferred this cycle |
| op_end | input | 1 | The operation is closing |
| addr | output | 6 | Current byte address, which is also the stored pointer |
| active | output | 1 | An operation is open |
| sect | output | 3 | Section code of the current operation, 7 = none |
| addr_bad | output | 1 | The last matched start was refused |
| terminate | output | 1 | One-cycle pulse when a status byte exceeds the allowed length |

## Verification
A wrong section decode shows up one cycle after a start as an incorrect `sect` code or a false `addr_bad`. It also shows up later as a wrap to the wrong base, at most eight bytes into a burst. A wrong step or wrap shows up on `addr` in the cycle after the offending `byte_done`. A lost `used` state in the status section shows up on the second byte, either as a missing `terminate` or as a premature one. A pointer that is not retained shows up on the first cycle of the next resumed start. The reference model compares every output on every clock, so each of these faults is reported in the cycle it reaches the ports.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int ADDR_W = 6;
  localparam int unsigned SPACE = 1 << ADDR_W;
  localparam int NSECT = 5;
  localparam int SECT_W = 3;

  typedef enum logic [SECT_W-1:0] {
    SEC_ALM0 = 3'd0,
    SEC_ALM1 = 3'd1,
    SEC_CTRL = 3'd2,
    SEC_TIME = 3'd3,
    SEC_STAT = 3'd4,
    SEC_NONE = 3'd7
  } sect_e;

  // base and length of each section, indexed by its code
  localparam int unsigned SECT_BASE [NSECT] = '{0, 8, 16, 48, 63};
  localparam int unsigned SECT_LEN  [NSECT] = '{8, 8, 1, 8, 1};

  // upper seven bits of the device select byte that opens this space
  localparam logic [6:0] DEV_TAG = 7'b1101111;

  function automatic logic [ADDR_W-1:0] sect_first(input int idx);
    return ADDR_W'(SECT_BASE[idx]);
  endfunction

  function automatic logic [ADDR_W-1:0] sect_last(input int idx);
    return ADDR_W'(SECT_BASE[idx] + SECT_LEN[idx] - 1);
  endfunction

  function automatic logic in_sect(input logic [31:0] a, input int idx);
    return (a >= SECT_BASE[idx]) && (a < SECT_BASE[idx] + SECT_LEN[idx]);
  endfunction

  function automatic logic dev_matches(input logic [7:0] dev);
    return (dev | 8'h01) == {DEV_TAG, 1'b1};
  endfunction

endpackage

// File: rtl/rsq_sect_decode.sv
module rsq_sect_decode
  import rsq_pkg::*;
#(
  parameter int RAW_W = 8
) (
  input  logic [RAW_W-1:0] addr_i,
  output sect_e            sect_o,
  output logic             hit_o,
  output logic             out_of_range_o
);

  logic [NSECT-1:0] hit_vec;
  logic [31:0]      addr_wide;

  assign addr_wide = 32'(addr_i);

  genvar g;
  generate
    for (g = 0; g < NSECT; g++) begin : g_hit
      assign hit_vec[g] = in_sect(addr_wide, g);
    end
  endgenerate

  assign out_of_range_o = addr_wide >= SPACE;
  assign hit_o          = |hit_vec;

  always_comb begin
    sect_o = SEC_NONE;
    for (int i = 0; i < NSECT; i++) begin
      if (hit_vec[i]) sect_o = sect_e'(SECT_W'(i));
    end
  end

endmodule

// File: rtl/rsq_sect_step.sv
module rsq_sect_step
  import rsq_pkg::*;
(
  input  sect_e             sect_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              wrap_o
);

  always_comb begin
    next_o = addr_i;
    wrap_o = 1'b0;
    for (int i = 0; i < NSECT; i++) begin
      if (sect_i == sect_e'(SECT_W'(i))) begin
        if (addr_i == sect_last(i)) begin
          next_o = sect_first(i);
          wrap_o = 1'b1;
        end else begin
          next_o = addr_i + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rsq_addr_seq.sv
module rsq_addr_seq
  import rsq_pkg::*;
#(
  parameter int RAW_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  input  logic [7:0]          start_dev,
  input  logic                start_from_ptr,
  input  logic [RAW_W-1:0]    start_addr,
  input  logic                byte_done,
  input  logic                op_end,
  output logic [ADDR_W-1:0]   addr,
  output logic                active,
  output logic [SECT_W-1:0]   sect,
  output logic                addr_bad,
  output logic                terminate
);

  logic [ADDR_W-1:0] cur_q;
  logic              active_q;
  sect_e             sect_q;
  logic              used_q;
  logic              bad_q;
  logic              term_q;

  // named events
  logic              sel_match;
  logic              start_take;
  logic              start_ok;
  logic              xfer_live;
  logic              term_ev;
  logic              adv_ev;
  logic              step_wrap;

  logic [RAW_W-1:0]  cand;
  sect_e             cand_sect;
  logic              cand_hit;
  logic              cand_oor;
  logic [ADDR_W-1:0] step_next;

  assign sel_match  = dev_matches(start_dev);
  assign start_take = start_valid && sel_match;
  assign cand       = start_from_ptr ? RAW_W'(cur_q) : start_addr;

  rsq_sect_decode #(.RAW_W(RAW_W)) u_decode (
    .addr_i         (cand),
    .sect_o         (cand_sect),
    .hit_o          (cand_hit),
    .out_of_range_o (cand_oor)
  );

  rsq_sect_step u_step (
    .sect_i (sect_q),
    .addr_i (cur_q),
    .next_o (step_next),
    .wrap_o (step_wrap)
  );

  assign start_ok  = start_take && cand_hit && !cand_oor;
  assign xfer_live = byte_done && active_q && !start_take;
  assign term_ev   = xfer_live && (sect_q == SEC_STAT) && used_q;
  assign adv_ev    = xfer_live && !term_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      active_q <= 1'b0;
      sect_q   <= SEC_NONE;
      used_q   <= 1'b0;
      bad_q    <= 1'b0;
      term_q   <= 1'b0;
    end else begin
      term_q <= term_ev;
      if (start_take) begin
        bad_q    <= !start_ok;
        sect_q   <= start_ok ? cand_sect : SEC_NONE;
        used_q   <= 1'b0;
        active_q <= start_ok;
        if (start_ok) cur_q <= cand[ADDR_W-1:0];
      end else begin
        if (adv_ev) begin
          cur_q  <= step_next;
          used_q <= 1'b1;
        end
        if (term_ev || op_end) active_q <= 1'b0;
      end
    end
  end

  assign addr      = cur_q;
  assign active    = active_q;
  assign sect      = sect_q;
  assign addr_bad  = bad_q;
  assign terminate = term_q;

endmodule

// File: rtl/rsq_addr_seq_chk.sv
module rsq_addr_seq_chk
  import rsq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              byte_done,
  input logic              op_end,
  input logic              sel_match,
  input logic              start_ok,
  input logic              adv_ev,
  input logic              step_wrap,
  input logic [ADDR_W-1:0] addr,
  input logic              active,
  input logic [SECT_W-1:0] sect,
  input logic              addr_bad,
  input logic              terminate
);

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (active && !addr_bad));

  // R3
  foreign_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !sel_match && !byte_done && !op_end) |=>
      ($stable(addr) && $stable(active) && $stable(sect) && $stable(addr_bad)));

  // R4
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && sect != 3'd2 && sect != 3'd4) |=> (addr != $past(addr) && $stable(sect)));

  // R5
  wrap_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ev && step_wrap) |=> (addr <= $past(addr)));

  // R6
  term_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminate |-> (!active && $past(active) && $stable(addr) && sect == 3'd4));

  // R6
  term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminate |=> !terminate);

  // R7
  bad_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad |-> (!active && sect == 3'd7));

  // R9
  idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !active && !start_valid) |=> $stable(addr));

  // R10
  end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_end && !start_valid && !byte_done) |=> (!active && $stable(addr)));

endmodule

bind rsq_addr_seq rsq_addr_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .byte_done   (byte_done),
  .op_end      (op_end),
  .sel_match   (sel_match),
  .start_ok    (start_ok),
  .adv_ev      (adv_ev),
  .step_wrap   (step_wrap),
  .addr        (addr),
  .active      (active),
  .sect        (sect),
  .addr_bad    (addr_bad),
  .terminate   (terminate)
);

// File: tb/rsq_addr_seq_tb.sv
`timescale 1ns/1ps
module rsq_addr_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic [7:0] start_dev = 8'h00;
  logic       start_from_ptr = 1'b0;
  logic [7:0] start_addr = 8'h00;
  logic       byte_done = 1'b0;
  logic       op_end = 1'b0;
  logic [5:0] addr;
  logic       active;
  logic [2:0] sect;
  logic       addr_bad;
  logic       terminate;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cycles = 0;

  always #2 clk = ~clk;

  rsq_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_dev(start_dev),
    .start_from_ptr(start_from_ptr), .start_addr(start_addr),
    .byte_done(byte_done), .op_end(op_end), .addr(addr), .active(active),
    .sect(sect), .addr_bad(addr_bad), .terminate(terminate)
  );

  // behavioural reference model
  int m_addr, m_act, m_sect, m_bad, m_term, m_used;

  function automatic int ref_sect(int a);
    if (a >= 0 && a < 16) return a / 8;
    if (a == 16) return 2;
    if (a >= 48 && a <= 55) return 3;
    if (a == 63) return 4;
    return 7;
  endfunction

  function automatic int ref_next(int a, int s);
    int base, len;
    case (s)
      0: begin base = 0;  len = 8; end
      1: begin base = 8;  len = 8; end
      2: begin base = 16; len = 1; end
      3: begin base = 48; len = 8; end
      default: begin base = 63; len = 1; end
    endcase
    return base + ((a - base + 1) % len);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_act = 0; m_sect = 7; m_bad = 0; m_term = 0; m_used = 0;
    end else begin
      int tn, a, s;
      tn = 0;
      if (start_valid && (start_dev[7:1] == 7'h6F)) begin
        a = start_from_ptr ? m_addr : int'(start_addr);
        s = ref_sect(a);
        m_used = 0;
        m_bad = (s == 7);
        m_sect = s;
        if (s != 7) begin m_addr = a; m_act = 1; end
        else m_act = 0;
      end else begin
        if (byte_done && m_act == 1) begin
          if (m_sect == 4 && m_used == 1) begin tn = 1; m_act = 0; end
          else begin m_addr = ref_next(m_addr, m_sect); m_used = 1; end
        end
        if (op_end) m_act = 0;
      end
      m_term = tn;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 model addr", int'(addr), m_addr);
      chk("R10 model active", int'(active), m_act);
      chk("R2 model sect", int'(sect), m_sect);
      chk("R7 model addr_bad", int'(addr_bad), m_bad);
      chk("R6 model terminate", int'(terminate), m_term);
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic go(input logic [7:0] dev, input logic from_ptr, input logic [7:0] a,
                    input logic bd, input logic oe);
    start_valid = 1'b1; start_dev = dev; start_from_ptr = from_ptr; start_addr = a;
    byte_done = bd; op_end = oe;
    cyc();
    start_valid = 1'b0; start_from_ptr = 1'b0; byte_done = 1'b0; op_end = 1'b0;
  endtask

  task automatic xfer();
    byte_done = 1'b1;
    cyc();
    byte_done = 1'b0;
  endtask

  task automatic close_op();
    op_end = 1'b1;
    cyc();
    op_end = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 addr", addr, 0);
    chk("R1 active", active, 0);
    chk("R1 sect", sect, 7);
    chk("R1 addr_bad", addr_bad, 0);
    chk("R1 terminate", terminate, 0);

    // R3 foreign select byte
    go(8'hA0, 1'b0, 8'h05, 1'b0, 1'b0);
    chk("R3 addr", addr, 0);
    chk("R3 active", active, 0);

    // R2 matched start in alarm 0
    go(8'hDE, 1'b0, 8'h05, 1'b0, 1'b0);
    chk("R2 addr", addr, 5);
    chk("R2 active", active, 1);
    chk("R2 sect", sect, 0);

    // R4 / R5 burst with wrap in alarm 0
    xfer(); chk("R4 step", addr, 6);
    xfer(); chk("R4 step", addr, 7);
    xfer(); chk("R5 wrap 07->00", addr, 0);
    xfer(); chk("R4 step after wrap", addr, 1);

    // R10 close, R9 idle byte
    close_op();
    chk("R10 active", active, 0);
    chk("R10 addr kept", addr, 1);
    xfer(); chk("R9 idle byte", addr, 1);

    // R8 resume from pointer, start_addr ignored
    go(8'hDF, 1'b1, 8'h30, 1'b0, 1'b0);
    chk("R8 resume addr", addr, 1);
    chk("R8 resume sect", sect, 0);
    close_op();

    // R5 control byte steps to itself
    go(8'hDE, 1'b0, 8'h10, 1'b0, 1'b0);
    chk("R2 ctrl sect", sect, 2);
    xfer(); xfer();
    chk("R5 ctrl stays", addr, 16);

    // R5 wrap in time section and alarm 1
    go(8'hDE, 1'b0, 8'h37, 1'b0, 1'b0);
    chk("R2 time sect", sect, 3);
    xfer(); chk("R5 wrap 37->30", addr, 48);
    go(8'hDE, 1'b0, 8'h0F, 1'b0, 1'b0);
    xfer(); chk("R5 wrap 0F->08", addr, 8);

    // R6 status single byte
    go(8'hDE, 1'b0, 8'h3F, 1'b0, 1'b0);
    chk("R2 status sect", sect, 4);
    xfer();
    chk("R6 first byte addr", addr, 63);
    chk("R6 first byte no term", terminate, 0);
    xfer();
    chk("R6 terminate", terminate, 1);
    chk("R6 active dropped", active, 0);
    chk("R6 addr kept", addr, 63);
    cyc();
    chk("R6 pulse ends", terminate, 0);

    // R7 invalid starts
    go(8'hDE, 1'b0, 8'h20, 1'b0, 1'b0);
    chk("R7 gap flag", addr_bad, 1);
    chk("R7 gap addr kept", addr, 63);
    chk("R7 gap sect", sect, 7);
    go(8'hDE, 1'b0, 8'h45, 1'b0, 1'b0);
    chk("R7 range flag", addr_bad, 1);
    chk("R7 range active", active, 0);
    go(8'hDE, 1'b0, 8'h38, 1'b0, 1'b0);
    chk("R7 gap 38 flag", addr_bad, 1);

    // R11 start beats byte_done and op_end
    go(8'hDE, 1'b0, 8'h08, 1'b1, 1'b1);
    chk("R11 addr", addr, 8);
    chk("R11 active", active, 1);
    chk("R7 flag cleared", addr_bad, 0);
    xfer(); chk("R4 alarm1 step", addr, 9);
    chk("R4 alarm1 sect", sect, 1);

    cyc();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule